// File: doc/BRIEF.md
# Per-Access Auto-Precharge Decider

This block sits beside a DRAM command scheduler. In the cycle that the scheduler issues a column read or column write, it compares the address of that command against every slot of the pending read queue and the pending write queue. If no unserved pending request targets the same rank, bank and row, the open row is no longer useful. The block then asks for an auto-precharge to be attached to the column command for that rank and bank. If any such request is still waiting, the row is left open so that the request can hit it.

The decision is combinational. It is built from the queue state the scheduler already holds in registers. The decision is an enumerated value with four cases:
- `DEC_IDLE`: no column command is issued, or the block is in reset.
- `DEC_HOLD_OPEN`: a matching unserved request exists in either queue.
- `DEC_BLOCKED`: the row could close, but the timing checker does not allow an auto-precharge now.
- `DEC_CLOSE`: the request pulse is raised.

A counter records each auto-precharge that the downstream command path actually accepts.

Top module: `autopre_decider`

## Requirements
- R1: When `col_issue` is 0, `ap_req` is 0 in that cycle whatever the queue contents are.
- R2: A read-queue slot with valid=1, served=0, and rank, bank and row all equal to the issued command's fields forces `ap_req` to 0.
- R3: A write-queue slot with valid=1, served=0 and a full rank/bank/row match forces `ap_req` to 0, even when the read queue has no match.
- R4: Slots with valid=0, or with served=1, never suppress the auto-precharge, even if their address matches.
- R5: A slot matches only if all three fields match. A slot that differs from the issued command in row alone, in bank alone, or in rank alone does not suppress the auto-precharge.
- R6: `ap_req` is 1 only while `ap_allowed` is 1. With `ap_allowed` at 0 and otherwise closing conditions, `ap_req` is 0.
- R7: Whenever `ap_req` is 1, `ap_rank` and `ap_bank` equal `col_rank` and `col_bank` of the same cycle.
- R8: `ap_count` increases by exactly one at a clock edge where `ap_req` and `ap_accept` are both 1, and holds its value at every other edge. `ap_accept` with `ap_req` at 0 has no effect.
- R9: While `rst_n` is 0, `ap_req` is 0 and `ap_count` is cleared to 0.
- R10: The decision is combinational. `ap_req` reflects the inputs of the same cycle with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_issue | input | 1 | A column read/write is issued this cycle |
| col_rank | input | RANK_W | Rank of issued column command |
| col_bank | input | BANK_W | Bank of issued column command |
| col_row | input | ROW_W | Row of issued column command |
| rdq_valid | input | RD_DEPTH | Read slot occupied flags |
| rdq_served | input | RD_DEPTH | Read slot already-served flags |
| rdq_rank | input | RD_DEPTH*RANK_W | Read slot ranks, slot i at bits [i*RANK_W +: RANK_W] |
| rdq_bank | input | RD_DEPTH*BANK_W | Read slot banks, same packing |
| rdq_row | input | RD_DEPTH*ROW_W | Read slot rows, same packing |
| wrq_valid | input | WR_DEPTH | Write slot occupied flags |
| wrq_served | input | WR_DEPTH | Write slot already-served flags |
| wrq_rank | input | WR_DEPTH*RANK_W | Write slot ranks |
| wrq_bank | input | WR_DEPTH*BANK_W | Write slot banks |
| wrq_row | input | WR_DEPTH*ROW_W | Write slot rows |
| ap_allowed | input | 1 | Timing checker permits auto-precharge now |
| ap_accept | input | 1 | Downstream took the auto-precharge |
| ap_req | output | 1 | Auto-precharge request pulse |
| ap_rank | output | RANK_W | Rank for the auto-precharge |
| ap_bank | output | BANK_W | Bank for the auto-precharge |
| ap_count | output | CNT_W | Count of accepted auto-precharges |

## Verification
`ap_req`, `ap_rank` and `ap_bank` are due in the same cycle as the stimulus. The bench applies inputs on the falling edge and samples one time unit later, before any rising edge can intervene. `ap_count` is due one rising edge after a cycle with `ap_req` and `ap_accept` both high. The counter checks therefore drive on the falling edge, wait for the next rising edge, and sample just after it. `ap_accept` is dropped on the following falling edge so that no extra edge is counted.

// File: rtl/apd_pkg.sv
package apd_pkg;
    typedef enum logic [1:0] {
        DEC_IDLE      = 2'd0,
        DEC_HOLD_OPEN = 2'd1,
        DEC_BLOCKED   = 2'd2,
        DEC_CLOSE     = 2'd3
    } ap_decision_e;
endpackage

// File: rtl/apd_match_scan.sv
module apd_match_scan #(
    parameter int DEPTH  = 8,
    parameter int RANK_W = 1,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14
) (
    input  logic [DEPTH-1:0]        slot_valid,
    input  logic [DEPTH-1:0]        slot_served,
    input  logic [DEPTH*RANK_W-1:0] slot_rank,
    input  logic [DEPTH*BANK_W-1:0] slot_bank,
    input  logic [DEPTH*ROW_W-1:0]  slot_row,
    input  logic [RANK_W-1:0]       key_rank,
    input  logic [BANK_W-1:0]       key_bank,
    input  logic [ROW_W-1:0]        key_row,
    output logic                    any_hit
);
    logic [DEPTH-1:0] hit_vec;

    // One comparator per slot, all in parallel.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign hit_vec[i] = slot_valid[i] && !slot_served[i]
                         && (slot_rank[i*RANK_W +: RANK_W] == key_rank)
                         && (slot_bank[i*BANK_W +: BANK_W] == key_bank)
                         && (slot_row[i*ROW_W +: ROW_W]    == key_row);
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/apd_counter.sv
module apd_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> count == $past(count) + 1'b1);
    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/autopre_decider.sv
module autopre_decider
    import apd_pkg::*;
#(
    parameter int RANK_W   = 1,
    parameter int BANK_W   = 3,
    parameter int ROW_W    = 14,
    parameter int RD_DEPTH = 8,
    parameter int WR_DEPTH = 8,
    parameter int CNT_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       col_issue,
    input  logic [RANK_W-1:0]          col_rank,
    input  logic [BANK_W-1:0]          col_bank,
    input  logic [ROW_W-1:0]           col_row,
    input  logic [RD_DEPTH-1:0]        rdq_valid,
    input  logic [RD_DEPTH-1:0]        rdq_served,
    input  logic [RD_DEPTH*RANK_W-1:0] rdq_rank,
    input  logic [RD_DEPTH*BANK_W-1:0] rdq_bank,
    input  logic [RD_DEPTH*ROW_W-1:0]  rdq_row,
    input  logic [WR_DEPTH-1:0]        wrq_valid,
    input  logic [WR_DEPTH-1:0]        wrq_served,
    input  logic [WR_DEPTH*RANK_W-1:0] wrq_rank,
    input  logic [WR_DEPTH*BANK_W-1:0] wrq_bank,
    input  logic [WR_DEPTH*ROW_W-1:0]  wrq_row,
    input  logic                       ap_allowed,
    input  logic                       ap_accept,
    output logic                       ap_req,
    output logic [RANK_W-1:0]          ap_rank,
    output logic [BANK_W-1:0]          ap_bank,
    output logic [CNT_W-1:0]           ap_count
);
    logic         rd_hit;
    logic         wr_hit;
    ap_decision_e decision;

    apd_match_scan #(.DEPTH(RD_DEPTH), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rd_scan (
        .slot_valid (rdq_valid),
        .slot_served(rdq_served),
        .slot_rank  (rdq_rank),
        .slot_bank  (rdq_bank),
        .slot_row   (rdq_row),
        .key_rank   (col_rank),
        .key_bank   (col_bank),
        .key_row    (col_row),
        .any_hit    (rd_hit)
    );

    apd_match_scan #(.DEPTH(WR_DEPTH), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_wr_scan (
        .slot_valid (wrq_valid),
        .slot_served(wrq_served),
        .slot_rank  (wrq_rank),
        .slot_bank  (wrq_bank),
        .slot_row   (wrq_row),
        .key_rank   (col_rank),
        .key_bank   (col_bank),
        .key_row    (col_row),
        .any_hit    (wr_hit)
    );

    // Decision: same-cycle, from the registered queue view.
    always_comb begin
        if (!rst_n || !col_issue)   decision = DEC_IDLE;
        else if (rd_hit || wr_hit)  decision = DEC_HOLD_OPEN;
        else if (!ap_allowed)       decision = DEC_BLOCKED;
        else                        decision = DEC_CLOSE;
    end

    // Outputs driven from the decision.
    always_comb begin
        ap_req  = 1'b0;
        ap_rank = col_rank;
        ap_bank = col_bank;
        unique case (decision)
            DEC_CLOSE:                           ap_req = 1'b1;
            DEC_IDLE, DEC_HOLD_OPEN, DEC_BLOCKED: ap_req = 1'b0;
            default:                             ap_req = 1'b0;
        endcase
    end

    apd_counter #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (ap_req && ap_accept),
        .count(ap_count)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !col_issue |-> !ap_req);
    assert_read_hit_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> !ap_req);
    assert_write_hit_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |-> !ap_req);
    assert_needs_allowed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req |-> ap_allowed);
    assert_target_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req |-> (ap_rank == col_rank && ap_bank == col_bank));
endmodule

// File: tb/autopre_decider_test.sv
module autopre_decider_test;
    localparam int CLK_P  = 10;
    localparam int RANK_W = 1;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 14;
    localparam int RD_D   = 8;
    localparam int WR_D   = 8;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic col_issue = 1'b0;
    logic [RANK_W-1:0] col_rank = '0;
    logic [BANK_W-1:0] col_bank = '0;
    logic [ROW_W-1:0]  col_row = '0;
    logic [RD_D-1:0] rdq_valid = '0, rdq_served = '0;
    logic [RD_D*RANK_W-1:0] rdq_rank = '0;
    logic [RD_D*BANK_W-1:0] rdq_bank = '0;
    logic [RD_D*ROW_W-1:0]  rdq_row = '0;
    logic [WR_D-1:0] wrq_valid = '0, wrq_served = '0;
    logic [WR_D*RANK_W-1:0] wrq_rank = '0;
    logic [WR_D*BANK_W-1:0] wrq_bank = '0;
    logic [WR_D*ROW_W-1:0]  wrq_row = '0;
    logic ap_allowed = 1'b1;
    logic ap_accept = 1'b0;
    logic ap_req;
    logic [RANK_W-1:0] ap_rank;
    logic [BANK_W-1:0] ap_bank;
    logic [CNT_W-1:0]  ap_count;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_cnt  = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    autopre_decider #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
                      .RD_DEPTH(RD_D), .WR_DEPTH(WR_D), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .col_issue(col_issue),
        .col_rank(col_rank), .col_bank(col_bank), .col_row(col_row),
        .rdq_valid(rdq_valid), .rdq_served(rdq_served),
        .rdq_rank(rdq_rank), .rdq_bank(rdq_bank), .rdq_row(rdq_row),
        .wrq_valid(wrq_valid), .wrq_served(wrq_served),
        .wrq_rank(wrq_rank), .wrq_bank(wrq_bank), .wrq_row(wrq_row),
        .ap_allowed(ap_allowed), .ap_accept(ap_accept),
        .ap_req(ap_req), .ap_rank(ap_rank), .ap_bank(ap_bank), .ap_count(ap_count)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic clear_q();
        rdq_valid = '0; rdq_served = '0; wrq_valid = '0; wrq_served = '0;
        rdq_rank = '0; rdq_bank = '0; rdq_row = '0;
        wrq_rank = '0; wrq_bank = '0; wrq_row = '0;
    endtask

    task automatic set_rd(input int i, input bit s, input int rk, input int bk, input int rw);
        rdq_valid[i] = 1'b1; rdq_served[i] = s;
        rdq_rank[i*RANK_W +: RANK_W] = RANK_W'(rk);
        rdq_bank[i*BANK_W +: BANK_W] = BANK_W'(bk);
        rdq_row[i*ROW_W +: ROW_W]    = ROW_W'(rw);
    endtask

    task automatic set_wr(input int i, input bit s, input int rk, input int bk, input int rw);
        wrq_valid[i] = 1'b1; wrq_served[i] = s;
        wrq_rank[i*RANK_W +: RANK_W] = RANK_W'(rk);
        wrq_bank[i*BANK_W +: BANK_W] = BANK_W'(bk);
        wrq_row[i*ROW_W +: ROW_W]    = ROW_W'(rw);
    endtask

    task automatic issue(input int rk, input int bk, input int rw);
        col_issue = 1'b1;
        col_rank = RANK_W'(rk); col_bank = BANK_W'(bk); col_row = ROW_W'(rw);
    endtask

    task automatic t_reset();
        clear_q(); issue(1, 5, 100); ap_allowed = 1'b1;
        #1;
        check("R9 req in reset", int'(ap_req), 0);
        check("R9 count in reset", int'(ap_count), 0);
        @(negedge clk); rst_n = 1'b1; col_issue = 1'b0;
    endtask

    task automatic t_idle();
        @(negedge clk); clear_q(); issue(1, 2, 7); col_issue = 1'b0; #1;
        check("R1 no column command", int'(ap_req), 0);
    endtask

    task automatic t_empty_close();
        @(negedge clk); clear_q(); issue(1, 6, 300); #1;
        check("R10 same-cycle close", int'(ap_req), 1);
        check("R7 rank", int'(ap_rank), 1);
        check("R7 bank", int'(ap_bank), 6);
        @(negedge clk); issue(0, 3, 300); #1;
        check("R7 bank follows command", int'(ap_bank), 3);
    endtask

    task automatic t_read_hit();
        @(negedge clk); clear_q(); issue(0, 4, 1234);
        set_rd(3, 0, 0, 4, 1234); set_rd(0, 0, 1, 1, 9); #1;
        check("R2 read match keeps open", int'(ap_req), 0);
    endtask

    task automatic t_write_hit();
        @(negedge clk); clear_q(); issue(1, 7, 55);
        set_wr(7, 0, 1, 7, 55); set_rd(2, 0, 0, 7, 55); #1;
        check("R3 write match keeps open", int'(ap_req), 0);
    endtask

    task automatic t_ignored();
        @(negedge clk); clear_q(); issue(0, 2, 88);
        set_rd(1, 1, 0, 2, 88); set_wr(5, 1, 0, 2, 88); #1;
        check("R4 served slots ignored", int'(ap_req), 1);
        @(negedge clk); clear_q();
        rdq_rank = '0; rdq_bank[1*BANK_W +: BANK_W] = 3'd2;
        rdq_row[1*ROW_W +: ROW_W] = 14'd88; #1;
        check("R4 invalid slot ignored", int'(ap_req), 1);
    endtask

    task automatic t_partial();
        @(negedge clk); clear_q(); issue(1, 5, 400);
        set_rd(0, 0, 1, 5, 401); #1;
        check("R5 row differs", int'(ap_req), 1);
        @(negedge clk); clear_q(); set_wr(4, 0, 1, 4, 400); #1;
        check("R5 bank differs", int'(ap_req), 1);
        @(negedge clk); clear_q(); set_rd(6, 0, 0, 5, 400); #1;
        check("R5 rank differs", int'(ap_req), 1);
    endtask

    task automatic t_allowed();
        @(negedge clk); clear_q(); issue(0, 1, 10); ap_allowed = 1'b0; #1;
        check("R6 not allowed", int'(ap_req), 0);
        @(negedge clk); ap_allowed = 1'b1; #1;
        check("R6 allowed again", int'(ap_req), 1);
    endtask

    task automatic count_step(input bit iss, input bit acc, input string tag);
        @(negedge clk); clear_q(); issue(0, 0, 20); col_issue = iss; ap_accept = acc;
        if (iss && acc) exp_cnt++;
        @(posedge clk); #1;
        check(tag, int'(ap_count), exp_cnt);
        @(negedge clk); ap_accept = 1'b0; col_issue = 1'b0;
    endtask

    task automatic t_count();
        count_step(1, 1, "R8 accepted increments");
        count_step(1, 0, "R8 not accepted holds");
        count_step(0, 1, "R8 accept without request ignored");
        count_step(1, 1, "R8 second increment");
        @(negedge clk); clear_q(); issue(0, 0, 20); set_rd(0, 0, 0, 0, 20); ap_accept = 1'b1;
        @(posedge clk); #1;
        check("R8 kept-open not counted", int'(ap_count), exp_cnt);
        @(negedge clk); ap_accept = 1'b0; col_issue = 1'b0;
    endtask

    initial begin
        t_reset();
        t_idle();
        t_empty_close();
        t_read_hit();
        t_write_hit();
        t_ignored();
        t_partial();
        t_allowed();
        t_count();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule